// File: doc/BRIEF.md
# Selectable-Rate Timestamp Counter

This block keeps a free-running timestamp that software can read at any moment over a simple register bus. A configuration word chooses how fast the timestamp advances. Source 0 is a nanosecond count that moves by the system clock period, which is 20 at the default 50 MHz, on every clock. Source 1 adds one per microsecond. Source 2 adds one per millisecond. The slow rates come from an internal prescaler, and the timestamp wraps silently when it reaches the top of its range.

Software clears the timestamp in two writes. The first write sends the current source with the clear bit set, and the counter then sits at zero. The second write sends the same source with the clear bit low, and counting starts again from zero. A read of the count register returns a 32-bit value that is captured on a single clock edge. It cannot tear.

Top module: `tstamp_counter`

## Requirements
- R1: After reset the count is 0, and the configuration register reads 0 (source 0, clear bit low).
- R2: The configuration register sits at address 0x600 and the count register at 0x602. Any other address reads 0, and writes to 0x602 have no effect. Read data and `bus_rvalid` appear in the cycle after `bus_rd` is high.
- R3: With source 0 and the clear bit low, the count rises by CLK_NS (default 20) on every clock.
- R4: With source 1, the count rises by 1 every CYC_PER_US = 1000/CLK_NS clocks (default 50). The first step comes that many clocks after a prescaler restart.
- R5: With source 2, the count rises by 1 every CYC_PER_US × US_PER_MS clocks (default 50,000).
- R6: Writing configuration bit 8 = 1 forces the count to 0 from the next clock and keeps it there. Bit 8 reads back as written.
- R7: After bit 8 is written back to 0, counting resumes from 0, and the source stored before the clear is kept.
- R8: The source field is configuration bits 7:0. A write with a field value above 2 leaves the stored source unchanged, though bit 8 is still taken. The stored source never exceeds 2.
- R9: The prescaler restarts in two cases: on a configuration write that changes the source, and on any write with bit 8 set. It is also held while bit 8 is set. Rewriting the same source does not disturb it.
- R10: The count wraps modulo 2^CNT_W without stopping.
- R11: A count read returns the count value present at the clock edge where `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |

## Verification
The assertions check these properties on every clock:
- the count is zero in the cycle after the clear bit is high;
- the count rises by exactly CLK_NS under source 0 and stays still between microsecond ticks under the slower sources;
- the stored source stays in range;
- the microsecond ticks are spaced correctly after each prescaler restart;
- every read strobe gets a valid strobe one cycle later.

Other behaviours can only be shown by the bench scenarios, which compare every read against a behavioural model:
- the millisecond rate;
- the address decode and the read-only count register;
- preservation of the source across a clear;
- the rejected out-of-range writes;
- wraparound, shown on a second, narrow instance.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      SRC_NS = 2'd0,
      SRC_US = 2'd1,
      SRC_MS = 2'd2
   } tsc_src_e;

   localparam int unsigned SRC_MAX     = 2;
   localparam int unsigned SRC_FIELD_W = 8;
   localparam int unsigned CLR_BIT     = 8;
endpackage

// File: rtl/tsc_cfg_reg.sv
module tsc_cfg_reg
   import tsc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CFG_ADDR = 'h600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output tsc_src_e          src,
   output logic              hold,
   output logic              restart
);
   logic     hit;
   logic     legal;
   tsc_src_e src_q;
   logic     hold_q;

   assign hit   = wr && (addr == ADDR_W'(CFG_ADDR));
   assign legal = (wdata[SRC_FIELD_W-1:0] <= SRC_FIELD_W'(SRC_MAX));
   assign restart = hit && (wdata[CLR_BIT] ||
                            (legal && (wdata[1:0] != src_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_NS;
         hold_q <= 1'b0;
      end else if (hit) begin
         hold_q <= wdata[CLR_BIT];
         if (legal) src_q <= tsc_src_e'(wdata[1:0]);
      end
   end

   assign src  = src_q;
   assign hold = hold_q;
endmodule

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
   parameter int unsigned CYC_PER_US = 50,
   parameter int unsigned US_PER_MS  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic us_tick,
   output logic ms_tick
);
   localparam int unsigned CW = $clog2(CYC_PER_US);
   localparam int unsigned UW = $clog2(US_PER_MS);

   generate
      if (CYC_PER_US < 2) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 2");
      end
      if (US_PER_MS < 2) begin : g_bad_us
         $error("US_PER_MS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cyc_q;
   logic [UW-1:0] us_q;

   assign us_tick = (cyc_q == CW'(CYC_PER_US - 1));
   assign ms_tick = us_tick && (us_q == UW'(US_PER_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         us_q  <= '0;
      end else if (clear) begin
         cyc_q <= '0;
         us_q  <= '0;
      end else begin
         cyc_q <= us_tick ? '0 : cyc_q + 1'b1;
         if (us_tick) us_q <= ms_tick ? '0 : us_q + 1'b1;
      end
   end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum
   import tsc_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned FINE_STEP = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  tsc_src_e         src,
   input  logic             us_tick,
   input  logic             ms_tick,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] fine_inc;
   logic [CNT_W-1:0] inc;
   logic [CNT_W-1:0] count_q;

   generate
      if (FINE_STEP == 1) begin : g_unit_step
         assign fine_inc = CNT_W'(1);
      end else begin : g_wide_step
         assign fine_inc = CNT_W'(FINE_STEP);
      end
   endgenerate

   always_comb begin
      inc = '0;
      unique case (src)
         SRC_NS:  inc = fine_inc;
         SRC_US:  inc = CNT_W'(us_tick);
         SRC_MS:  inc = CNT_W'(ms_tick);
         default: inc = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (hold) count_q <= '0;
      else           count_q <= count_q + inc;
   end

   assign count = count_q;
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
   import tsc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned CLK_NS    = 20,
   parameter int unsigned US_PER_MS = 1000,
   parameter int unsigned CFG_ADDR  = 'h600,
   parameter int unsigned CNT_ADDR  = 'h602
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid
);
   localparam int unsigned CYC_PER_US = 1000 / CLK_NS;

   generate
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W <= CLR_BIT) begin : g_bad_data
         $error("DATA_W too narrow for the clear bit");
      end
      if (CLK_NS == 0 || (1000 % CLK_NS) != 0) begin : g_bad_clk
         $error("CLK_NS must divide 1000");
      end
   endgenerate

   tsc_src_e         cfg_src;
   logic             cfg_hold;
   logic             cfg_restart;
   logic             us_tick;
   logic             ms_tick;
   logic [CNT_W-1:0] count_q;
   logic [DATA_W-1:0] rd_mux;

   tsc_cfg_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .src(cfg_src), .hold(cfg_hold),
      .restart(cfg_restart)
   );

   tsc_prescaler #(
      .CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(cfg_restart | cfg_hold),
      .us_tick(us_tick), .ms_tick(ms_tick)
   );

   tsc_accum #(
      .CNT_W(CNT_W), .FINE_STEP(CLK_NS)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .src(cfg_src),
      .us_tick(us_tick), .ms_tick(ms_tick), .count(count_q)
   );

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(CFG_ADDR)) begin
         rd_mux[1:0]     = cfg_src;
         rd_mux[CLR_BIT] = cfg_hold;
      end else if (bus_addr == ADDR_W'(CNT_ADDR)) begin
         rd_mux[CNT_W-1:0] = count_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
   import tsc_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned FINE_STEP  = 20,
   parameter int unsigned CYC_PER_US = 50
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold,
   input logic             restart,
   input tsc_src_e         src,
   input logic             us_tick,
   input logic             ms_tick,
   input logic [CNT_W-1:0] count,
   input logic             bus_rd,
   input logic             bus_rvalid
);
   int unsigned gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gap_q <= 0;
      else if (restart || hold)    gap_q <= 0;
      else if (us_tick)            gap_q <= 0;
      else                         gap_q <= gap_q + 1;
   end

   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0));                                   // R6
   AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      src <= SRC_MS);                                            // R8
   AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && src == SRC_NS) |=>
         (count == $past(count) + CNT_W'(FINE_STEP)));           // R3
   AST_SLOW_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && src != SRC_NS && !us_tick) |=> $stable(count));  // R4
   AST_MS_ON_US: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |-> us_tick);                                      // R5
   AST_US_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      us_tick |-> (gap_q == CYC_PER_US - 1));                    // R9
   AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);                                    // R2
endmodule

bind tstamp_counter tsc_checker #(
   .CNT_W(CNT_W), .FINE_STEP(CLK_NS), .CYC_PER_US(1000 / CLK_NS)
) u_tsc_chk (
   .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .restart(cfg_restart),
   .src(cfg_src), .us_tick(us_tick), .ms_tick(ms_tick), .count(count_q),
   .bus_rd(bus_rd), .bus_rvalid(bus_rvalid)
);

// File: tb/tstamp_counter_tb_top.sv
module tstamp_counter_tb_top;
   localparam int  STEP   = 20;
   localparam int  CYC    = 50;
   localparam int  USMS   = 1000;
   localparam int  SMALLW = 8;
   localparam logic [11:0] A_CFG = 12'h600;
   localparam logic [11:0] A_CNT = 12'h602;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic        rvalid_a, rvalid_b;

   int    n_checks = 0;
   int    n_errors = 0;
   int    cycles = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   tstamp_counter dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_a), .bus_rvalid(rvalid_a)
   );

   tstamp_counter #(.CNT_W(SMALLW)) dut_small (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_b), .bus_rvalid(rvalid_b)
   );

   // behavioural model
   int          m_src, m_clr, m_cyc, m_us;
   longint      m_cnt, m_cnt_s;
   logic [31:0] m_rdata, m_rdata_s;
   logic        m_valid;
   bit          wrap_seen = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_src = 0; m_clr = 0; m_cyc = 0; m_us = 0;
         m_cnt = 0; m_cnt_s = 0; m_valid = 0;
         m_rdata = 0; m_rdata_s = 0;
      end else begin
         int inc;
         bit restart;
         m_valid = bus_rd;
         if (bus_rd) begin
            if (bus_addr == A_CFG) begin
               m_rdata = 32'(m_src) | (m_clr ? 32'h100 : 32'h0);
               m_rdata_s = m_rdata;
            end else if (bus_addr == A_CNT) begin
               m_rdata = 32'(m_cnt);
               m_rdata_s = 32'(m_cnt_s);
            end else begin
               m_rdata = 0; m_rdata_s = 0;
            end
         end
         inc = 0;
         if (m_src == 0) inc = STEP;
         else if (m_src == 1 && m_cyc == CYC-1) inc = 1;
         else if (m_src == 2 && m_cyc == CYC-1 && m_us == USMS-1) inc = 1;
         if (m_clr) begin
            m_cnt = 0; m_cnt_s = 0;
         end else begin
            m_cnt = (m_cnt + inc) % 64'h1_0000_0000;
            if (m_cnt_s + inc >= (1 << SMALLW)) wrap_seen = 1;
            m_cnt_s = (m_cnt_s + inc) % (1 << SMALLW);
         end
         restart = m_clr != 0;
         if (bus_wr && bus_addr == A_CFG &&
             (bus_wdata[8] || (bus_wdata[7:0] <= 2 && int'(bus_wdata[1:0]) != m_src)))
            restart = 1;
         if (restart) begin
            m_cyc = 0; m_us = 0;
         end else if (m_cyc == CYC-1) begin
            m_cyc = 0;
            m_us = (m_us == USMS-1) ? 0 : m_us + 1;
         end else m_cyc = m_cyc + 1;
         if (bus_wr && bus_addr == A_CFG) begin
            m_clr = bus_wdata[8];
            if (bus_wdata[7:0] <= 2) m_src = int'(bus_wdata[1:0]);
         end
      end
   end

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R11: value at the read edge)
   always @(negedge clk) begin
      if (rst_n) begin
         cycles++;
         chk(rvalid_a == m_valid, {cur_req, " valid"}, rvalid_a, m_valid);
         if (m_valid) begin
            chk(rdata_a == m_rdata, {cur_req, " R11 data"}, rdata_a, m_rdata);
            chk(rdata_b == m_rdata_s, {cur_req, " R10 narrow"}, rdata_b, m_rdata_s);
         end
      end
   end

   initial begin
      #(5.0 * 190000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      #0.1 d = rdata_a;
   endtask

   task automatic stream(logic [11:0] a, int n);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      repeat (n) @(negedge clk);
      bus_rd = 0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      cur_req = "R1";
      rd(A_CFG, v); chk(v == 32'h0, "R1 cfg", v, 0);
      wr(A_CFG, 32'h100);
      rd(A_CNT, v); chk(v == 32'h0, "R1 count", v, 0);
      wr(A_CFG, 32'h000);
      // R3 fine rate
      cur_req = "R3";
      stream(A_CNT, 40);
      // R2 decode, read-only count
      cur_req = "R2";
      rd(12'h604, v); chk(v == 32'h0, "R2 unmapped", v, 0);
      wr(A_CNT, 32'h1234);
      stream(A_CNT, 5);
      // R6 clear holds zero
      cur_req = "R6";
      wr(A_CFG, 32'h101);
      stream(A_CNT, 20);
      rd(A_CNT, v); chk(v == 32'h0, "R6 held", v, 0);
      rd(A_CFG, v); chk(v == 32'h101, "R6 cfg", v, 32'h101);
      // R7 resume from zero, source kept (src 1)
      cur_req = "R7";
      wr(A_CFG, 32'h001);
      rd(A_CFG, v); chk(v == 32'h1, "R7 src kept", v, 1);
      // R4 microsecond rate
      cur_req = "R4";
      stream(A_CNT, 260);
      rd(A_CNT, v); chk(v >= 32'd5 && v <= 32'd6, "R4 us count", v, 5);
      // R8 illegal source
      cur_req = "R8";
      wr(A_CFG, 32'h005);
      rd(A_CFG, v); chk(v == 32'h1, "R8 src unchanged", v, 1);
      wr(A_CFG, 32'h1FF);
      rd(A_CFG, v); chk(v == 32'h101, "R8 clear taken", v, 32'h101);
      wr(A_CFG, 32'h001);
      // R9 prescaler restart vs same-source write
      cur_req = "R9";
      stream(A_CNT, 30);
      wr(A_CFG, 32'h001);
      stream(A_CNT, 40);
      wr(A_CFG, 32'h000);
      wr(A_CFG, 32'h001);
      stream(A_CNT, 120);
      // R10 wrap on narrow instance under fine rate
      cur_req = "R10";
      wr(A_CFG, 32'h000);
      stream(A_CNT, 30);
      chk(wrap_seen, "R10 wrap observed", wrap_seen, 1);
      // R5 millisecond rate
      cur_req = "R5";
      wr(A_CFG, 32'h102);
      wr(A_CFG, 32'h002);
      stream(A_CNT, 101000);
      rd(A_CNT, v); chk(v == 32'd2, "R5 ms count", v, 2);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule